// File: doc/BRIEF.md
# Fuse Program Request Permission Checker

This block sits behind the program-address register of a one-time-programmable fuse controller. Software writes a packed page, row and column that names a single fuse bit. The block works out whether that bit may be burned and then either sends a one-bit set request to the fuse array or refuses. Four inputs decide the outcome: the program-enable bit of the configuration word, a sticky program-lock bit, a fixed table that ties protected rows to a lock fuse, and the value of that lock fuse read back from the array.

Each request follows the same fixed sequence. The block issues a read of the lock-fuse row and takes the row data one cycle later. It then issues the set or refuses, and in the last step it pulses done. Busy is high from the address write until the done pulse. A refused request, or a set that the array reports as failed, pulses the error event and sets a sticky error flag. Only software can clear that flag. A successful set to one of the upper columns of row 0 also pulses a refresh request for the per-page test-bit status flags.

Top module: `fuse_pgm_guard`

## Requirements
- R1: After reset, busy, set_req, rd_req, pgm_done, pgm_err, err_flag, tbit_refresh and lock_q are all 0.
- R2: While configuration bit 1 (program enable) is 0, every request is refused: no set_req, and pgm_err pulses with done.
- R3: lock_q is set by a lock_wr with lock_wdata 1 and is cleared only by reset. While it is set, page 0 rows 44 to 51 are refused, and row 52 is still allowed.
- R4: Page 0 protected rows map to a lock fuse: row 4 to (row 4, col 31); rows 8-11 to col 27, 12-19 to col 11, 20-27 to col 13, 28-35 to col 15, 37 to col 28, 64-71 to col 6, 72-79 to col 7, 80-87 to col 8, all in row 43. A request is refused when the mapped fuse reads 1.
- R5: On page 2, only bit positions from (row 129, col 0) to (row 255, col 27) may be set. Each is refused when the page 0 fuse at (row 43, col 16) reads 1. Any position outside that range is refused.
- R6: Requests to any page other than 0 and 2 are refused.
- R7: A page 0 row with no table entry and outside the locked range is allowed when program enable is 1.
- R8: When set_fail is high during the set cycle, pgm_err pulses and err_flag becomes 1.
- R9: Every accepted request gives exactly one pgm_done pulse, three cycles after the address write. err_flag stays 1 until err_clr.
- R10: tbit_refresh pulses with done only for a successful set at row 0, column 28 or higher.
- R11: busy is high from the cycle after the address write until done, and address writes made while busy are ignored.
- R12: The address register reads back as zero. The address layout is page [16:13], row [12:5], column [4:0].
- R13: In the cycle after the address write, rd_req is high and rd_row gives the lock-fuse row (43, or 4 for row 4). set_addr carries the written address during set_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | CFG_W | Configuration word; bit PGM_EN_BIT enables programming |
| addr_wr | input | 1 | Write strobe for the program-address register |
| addr_wdata | input | ADDR_W | Packed page/row/column written |
| addr_rdata | output | ADDR_W | Program-address readback (always zero) |
| lock_wr | input | 1 | Write strobe for the sticky program-lock bit |
| lock_wdata | input | 1 | Value written to the program-lock bit |
| lock_q | output | 1 | Current program-lock bit |
| err_clr | input | 1 | Clears the sticky error flag |
| busy | output | 1 | Request in progress |
| rd_req | output | 1 | Lock-fuse row read request to the array |
| rd_row | output | ROW_W | Page 0 row to read |
| rd_data | input | 2**COL_W | Row data, valid the cycle after rd_req |
| set_req | output | 1 | One-bit set request to the array |
| set_addr | output | ADDR_W | Bit to set |
| set_fail | input | 1 | Array reports the set failed, same cycle as set_req |
| pgm_done | output | 1 | One-cycle done event |
| pgm_err | output | 1 | One-cycle error event, with done |
| err_flag | output | 1 | Sticky error flag |
| tbit_refresh | output | 1 | Request to refresh test-bit status flags |

## Verification
The bench builds the block with its default parameters: a 17-bit address made of 4-bit page, 8-bit row and 5-bit column, program enable at configuration bit 1, a locked window of rows 44 to 51, and the open page-2 window from row 129 to row 255 column 27. These are the exact values the table and windows are defined for, so the bench reaches both edges of every window, a lock fuse that the block itself burns earlier in the run, and the self-protecting row-4 lock. A fuse model with registered read data closes the read-then-set loop.

// File: rtl/fuse_pgm_pkg.sv
package fuse_pgm_pkg;
   localparam int PAGE_W = 4;
   localparam int ROW_W  = 8;
   localparam int COL_W  = 5;
   localparam int NUM_LK = 10;

   typedef struct packed {
      logic [ROW_W-1:0] first;
      logic [ROW_W-1:0] last;
      logic [ROW_W-1:0] lk_row;
      logic [COL_W-1:0] lk_col;
   } lock_ent_t;

   localparam lock_ent_t LOCK_TABLE [NUM_LK] = '{
      '{first: 8'd4,  last: 8'd4,  lk_row: 8'd4,  lk_col: 5'd31},
      '{first: 8'd8,  last: 8'd11, lk_row: 8'd43, lk_col: 5'd27},
      '{first: 8'd12, last: 8'd19, lk_row: 8'd43, lk_col: 5'd11},
      '{first: 8'd20, last: 8'd27, lk_row: 8'd43, lk_col: 5'd13},
      '{first: 8'd28, last: 8'd35, lk_row: 8'd43, lk_col: 5'd15},
      '{first: 8'd37, last: 8'd37, lk_row: 8'd43, lk_col: 5'd28},
      '{first: 8'd64, last: 8'd71, lk_row: 8'd43, lk_col: 5'd6},
      '{first: 8'd72, last: 8'd79, lk_row: 8'd43, lk_col: 5'd7},
      '{first: 8'd80, last: 8'd87, lk_row: 8'd43, lk_col: 5'd8},
      '{first: 8'd0,  last: 8'd0,  lk_row: 8'd0,  lk_col: 5'd0}
   };
   localparam int NUM_LK_USED = 9;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_READ = 2'd1,
      SQ_CHK  = 2'd2,
      SQ_FIN  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/fuse_addr_split.sv
module fuse_addr_split #(
   parameter int PAGE_W = 4,
   parameter int ROW_W  = 8,
   parameter int COL_W  = 5,
   localparam int ADDR_W = PAGE_W + ROW_W + COL_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [PAGE_W-1:0] page,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic [ROW_W+COL_W-1:0] bitpos
);
   assign col    = addr[COL_W-1:0];
   assign row    = addr[COL_W +: ROW_W];
   assign page   = addr[COL_W+ROW_W +: PAGE_W];
   assign bitpos = addr[ROW_W+COL_W-1:0];
endmodule

// File: rtl/fuse_lock_map.sv
module fuse_lock_map
   import fuse_pgm_pkg::*;
#(
   parameter int LOCKED_ROW_LO = 44,
   parameter int LOCKED_ROW_HI = 51,
   parameter int OPEN_PAGE     = 2,
   parameter int OPEN_LO_ROW   = 129,
   parameter int OPEN_LO_COL   = 0,
   parameter int OPEN_HI_ROW   = 255,
   parameter int OPEN_HI_COL   = 27,
   parameter int OPEN_LK_ROW   = 43,
   parameter int OPEN_LK_COL   = 16,
   localparam int POS_W  = ROW_W + COL_W,
   localparam int OPEN_LO = OPEN_LO_ROW * (2**COL_W) + OPEN_LO_COL,
   localparam int OPEN_HI = OPEN_HI_ROW * (2**COL_W) + OPEN_HI_COL
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [ROW_W-1:0]  row,
   input  logic [POS_W-1:0]  bitpos,
   input  logic              prog_lock,
   output logic              hard_deny,
   output logic              need_lock,
   output logic [ROW_W-1:0]  lk_row,
   output logic [COL_W-1:0]  lk_col
);
   initial begin
      if (OPEN_LO > OPEN_HI)
         $error("open window is empty");
      if (LOCKED_ROW_LO > LOCKED_ROW_HI)
         $error("locked row window is empty");
   end

   logic [NUM_LK_USED-1:0] hit;
   logic                   tbl_hit;
   logic [ROW_W-1:0]       tbl_row;
   logic [COL_W-1:0]       tbl_col;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LK_USED; gi++) begin : g_ent
         assign hit[gi] = (row >= LOCK_TABLE[gi].first) && (row <= LOCK_TABLE[gi].last);
      end
   endgenerate

   always_comb begin
      tbl_hit = 1'b0;
      tbl_row = '0;
      tbl_col = '0;
      for (int i = 0; i < NUM_LK_USED; i++) begin
         if (hit[i]) begin
            tbl_hit = 1'b1;
            tbl_row = LOCK_TABLE[i].lk_row;
            tbl_col = LOCK_TABLE[i].lk_col;
         end
      end
   end

   logic in_locked_rows;
   logic in_open;
   assign in_locked_rows = (int'(row) >= LOCKED_ROW_LO) && (int'(row) <= LOCKED_ROW_HI);
   assign in_open        = (int'(bitpos) >= OPEN_LO) && (int'(bitpos) <= OPEN_HI);

   always_comb begin
      hard_deny = 1'b1;
      need_lock = 1'b0;
      lk_row    = '0;
      lk_col    = '0;
      if (page == '0) begin
         hard_deny = prog_lock && in_locked_rows;
         need_lock = tbl_hit;
         lk_row    = tbl_row;
         lk_col    = tbl_col;
      end else if (int'(page) == OPEN_PAGE) begin
         hard_deny = !in_open;
         need_lock = 1'b1;
         lk_row    = ROW_W'(OPEN_LK_ROW);
         lk_col    = COL_W'(OPEN_LK_COL);
      end
   end
endmodule

// File: rtl/fuse_pgm_seq.sv
module fuse_pgm_seq
   import fuse_pgm_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int FUSE_W     = 32,
   parameter int TBIT_COL   = 28,
   localparam int CW        = $clog2(FUSE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              enable,
   input  logic              hard_deny,
   input  logic              need_lock,
   input  logic [CW-1:0]     lk_col,
   input  logic [FUSE_W-1:0] rd_data,
   input  logic              set_fail,
   input  logic              err_clr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              busy,
   output logic              rd_req,
   output logic              set_req,
   output logic              pgm_done,
   output logic              pgm_err,
   output logic              err_flag,
   output logic              tbit_refresh
);
   seq_state_t st_q;
   logic       fail_q;
   logic       tbit_q;
   logic       allow;
   logic       is_tbit;

   assign allow   = enable && !hard_deny && !(need_lock && rd_data[lk_col]);
   assign is_tbit = (cur_addr[ADDR_W-1-4:CW] == '0) && (int'(cur_addr[CW-1:0]) >= TBIT_COL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         cur_addr <= '0;
         fail_q   <= 1'b0;
         tbit_q   <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         case (st_q)
            SQ_IDLE: if (start) begin
               cur_addr <= start_addr;
               st_q     <= SQ_READ;
            end
            SQ_READ: st_q <= SQ_CHK;
            SQ_CHK: begin
               fail_q <= !allow || set_fail;
               tbit_q <= allow && !set_fail && is_tbit;
               st_q   <= SQ_FIN;
            end
            default: st_q <= SQ_IDLE;
         endcase
         if (st_q == SQ_FIN && fail_q)
            err_flag <= 1'b1;
         else if (err_clr)
            err_flag <= 1'b0;
      end
   end

   assign busy         = (st_q != SQ_IDLE);
   assign rd_req       = (st_q == SQ_READ);
   assign set_req      = (st_q == SQ_CHK) && allow;
   assign pgm_done     = (st_q == SQ_FIN);
   assign pgm_err      = (st_q == SQ_FIN) && fail_q;
   assign tbit_refresh = (st_q == SQ_FIN) && tbit_q;
endmodule

// File: rtl/fuse_pgm_guard.sv
module fuse_pgm_guard
   import fuse_pgm_pkg::*;
#(
   parameter int CFG_W         = 8,
   parameter int PGM_EN_BIT    = 1,
   parameter int LOCKED_ROW_LO = 44,
   parameter int LOCKED_ROW_HI = 51,
   parameter int OPEN_PAGE     = 2,
   parameter int TBIT_COL      = 28,
   localparam int ADDR_W = PAGE_W + ROW_W + COL_W,
   localparam int FUSE_W = 2**COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_wdata,
   output logic [ADDR_W-1:0] addr_rdata,
   input  logic              lock_wr,
   input  logic              lock_wdata,
   output logic              lock_q,
   input  logic              err_clr,
   output logic              busy,
   output logic              rd_req,
   output logic [ROW_W-1:0]  rd_row,
   input  logic [FUSE_W-1:0] rd_data,
   output logic              set_req,
   output logic [ADDR_W-1:0] set_addr,
   input  logic              set_fail,
   output logic              pgm_done,
   output logic              pgm_err,
   output logic              err_flag,
   output logic              tbit_refresh
);
   initial begin
      if (PGM_EN_BIT >= CFG_W)
         $error("PGM_EN_BIT outside configuration word");
      if (TBIT_COL >= FUSE_W)
         $error("TBIT_COL outside row");
   end

   logic [ADDR_W-1:0]      cur_addr;
   logic [PAGE_W-1:0]      page;
   logic [ROW_W-1:0]       row;
   logic [COL_W-1:0]       col;
   logic [ROW_W+COL_W-1:0] bitpos;
   logic                   hard_deny;
   logic                   need_lock;
   logic [COL_W-1:0]       lk_col;

   assign addr_rdata = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (lock_wr && lock_wdata)
         lock_q <= 1'b1;
   end

   fuse_addr_split #(
      .PAGE_W (PAGE_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) split_i (
      .addr   (cur_addr),
      .page   (page),
      .row    (row),
      .col    (col),
      .bitpos (bitpos)
   );

   fuse_lock_map #(
      .LOCKED_ROW_LO (LOCKED_ROW_LO),
      .LOCKED_ROW_HI (LOCKED_ROW_HI),
      .OPEN_PAGE     (OPEN_PAGE)
   ) map_i (
      .page      (page),
      .row       (row),
      .bitpos    (bitpos),
      .prog_lock (lock_q),
      .hard_deny (hard_deny),
      .need_lock (need_lock),
      .lk_row    (rd_row),
      .lk_col    (lk_col)
   );

   fuse_pgm_seq #(
      .ADDR_W   (ADDR_W),
      .FUSE_W   (FUSE_W),
      .TBIT_COL (TBIT_COL)
   ) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (addr_wr),
      .start_addr   (addr_wdata),
      .enable       (cfg_word[PGM_EN_BIT]),
      .hard_deny    (hard_deny),
      .need_lock    (need_lock),
      .lk_col       (lk_col),
      .rd_data      (rd_data),
      .set_fail     (set_fail),
      .err_clr      (err_clr),
      .cur_addr     (cur_addr),
      .busy         (busy),
      .rd_req       (rd_req),
      .set_req      (set_req),
      .pgm_done     (pgm_done),
      .pgm_err      (pgm_err),
      .err_flag     (err_flag),
      .tbit_refresh (tbit_refresh)
   );

   assign set_addr = cur_addr;
endmodule

// File: rtl/fuse_pgm_guard_chk.sv
module fuse_pgm_guard_chk #(
   parameter int CFG_W      = 8,
   parameter int PGM_EN_BIT = 1,
   parameter int ADDR_W     = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CFG_W-1:0]  cfg_word,
   input logic              lock_q,
   input logic              err_clr,
   input logic              busy,
   input logic              rd_req,
   input logic              set_req,
   input logic [ADDR_W-1:0] set_addr,
   input logic              pgm_done,
   input logic              pgm_err,
   input logic              err_flag,
   input logic              tbit_refresh
);
   AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |-> cfg_word[PGM_EN_BIT]); // R2
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R3
   AST_SET_PAGE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |-> (set_addr[ADDR_W-1 -: 4] == 4'd0 || set_addr[ADDR_W-1 -: 4] == 4'd2)); // R6
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag); // R8
   AST_SET_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> pgm_done); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_done |=> !pgm_done); // R9
   AST_TBIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      tbit_refresh |-> (pgm_done && !pgm_err)); // R10
   AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_done |=> !busy); // R11
   AST_SET_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |-> $past(rd_req)); // R13
endmodule

bind fuse_pgm_guard fuse_pgm_guard_chk #(
   .CFG_W      (CFG_W),
   .PGM_EN_BIT (PGM_EN_BIT),
   .ADDR_W     (ADDR_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_word     (cfg_word),
   .lock_q       (lock_q),
   .err_clr      (err_clr),
   .busy         (busy),
   .rd_req       (rd_req),
   .set_req      (set_req),
   .set_addr     (set_addr),
   .pgm_done     (pgm_done),
   .pgm_err      (pgm_err),
   .err_flag     (err_flag),
   .tbit_refresh (tbit_refresh)
);

// File: tb/fuse_pgm_guard_tb.sv
`timescale 1ns/1ps
module fuse_pgm_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_word = 8'h02;
   logic        addr_wr = 1'b0;
   logic [16:0] addr_wdata = '0;
   logic [16:0] addr_rdata;
   logic        lock_wr = 1'b0;
   logic        lock_wdata = 1'b0;
   logic        lock_q;
   logic        err_clr = 1'b0;
   logic        busy;
   logic        rd_req;
   logic [7:0]  rd_row;
   logic [31:0] rd_data = '0;
   logic        set_req;
   logic [16:0] set_addr;
   logic        set_fail = 1'b0;
   logic        pgm_done;
   logic        pgm_err;
   logic        err_flag;
   logic        tbit_refresh;

   int checks = 0;
   int fails  = 0;
   logic [31:0] fuse0 [256];

   always #4 clk = ~clk;

   fuse_pgm_guard dut_i (.*);

   always @(posedge clk) begin
      if (rd_req) rd_data <= fuse0[rd_row];
      if (set_req && !set_fail && set_addr[16:13] == 4'd0)
         fuse0[set_addr[12:5]][set_addr[4:0]] <= 1'b1;
   end

   function automatic logic [16:0] mk(int pg, int rw, int cl);
      return {4'(pg), 8'(rw), 5'(cl)};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_req(string req, logic [16:0] a, logic exp_set, logic exp_err,
                         logic exp_t, int exp_row);
      @(negedge clk); addr_wr = 1'b1; addr_wdata = a;
      @(negedge clk); addr_wr = 1'b0;
      chk({req, " R11 busy"}, busy, 1);
      chk({req, " R13 rd_req"}, rd_req, 1);
      if (exp_row >= 0) chk({req, " R13 rd_row"}, rd_row, exp_row);
      @(negedge clk);
      chk({req, " set_req"}, set_req, exp_set);
      if (exp_set) chk({req, " R13 set_addr"}, set_addr, a);
      @(negedge clk);
      chk({req, " R9 done"}, pgm_done, 1);
      chk({req, " pgm_err"}, pgm_err, exp_err);
      chk({req, " R10 tbit"}, tbit_refresh, exp_t);
      @(negedge clk);
      chk({req, " R11 idle"}, busy, 0);
      chk({req, " R9 err_flag"}, err_flag, exp_err);
      err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0);
      chk("R1 set_req", set_req, 0);
      chk("R1 rd_req", rd_req, 0);
      chk("R1 done", pgm_done, 0);
      chk("R1 err", {pgm_err, err_flag, tbit_refresh}, 0);
      chk("R1 lock", lock_q, 0);
   endtask

   task automatic t_readback();
      @(negedge clk); addr_wr = 1'b1; addr_wdata = mk(0, 40, 9);
      @(negedge clk); addr_wr = 1'b0;
      chk("R12 readback zero", addr_rdata, 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_enable();
      cfg_word = 8'hFD;
      do_req("R2 disabled", mk(0, 40, 1), 0, 1, 0, 43 * 0 + 0 - 1);
      cfg_word = 8'h02;
   endtask

   task automatic t_unmapped();
      do_req("R7 row40", mk(0, 40, 2), 1, 0, 0, -1);
      do_req("R7 row90", mk(0, 90, 31), 1, 0, 0, -1);
   endtask

   task automatic t_table();
      do_req("R4 row20 open", mk(0, 20, 0), 1, 0, 0, 43);
      do_req("R4 burn 43/13", mk(0, 43, 13), 1, 0, 0, -1);
      do_req("R4 row20 locked", mk(0, 20, 1), 0, 1, 0, 43);
      do_req("R4 row27 locked", mk(0, 27, 5), 0, 1, 0, 43);
      do_req("R4 row19 open", mk(0, 19, 0), 1, 0, 0, 43);
      do_req("R4 row4 open", mk(0, 4, 0), 1, 0, 0, 4);
      do_req("R4 burn 4/31", mk(0, 4, 31), 1, 0, 0, 4);
      do_req("R4 row4 locked", mk(0, 4, 2), 0, 1, 0, 4);
   endtask

   task automatic t_sticky();
      do_req("R3 row44 before", mk(0, 44, 0), 1, 0, 0, -1);
      @(negedge clk); lock_wr = 1'b1; lock_wdata = 1'b1;
      @(negedge clk); lock_wr = 1'b0;
      do_req("R3 row44", mk(0, 44, 1), 0, 1, 0, -1);
      do_req("R3 row51", mk(0, 51, 31), 0, 1, 0, -1);
      do_req("R3 row52", mk(0, 52, 0), 1, 0, 0, -1);
      @(negedge clk); lock_wr = 1'b1; lock_wdata = 1'b0;
      @(negedge clk); lock_wr = 1'b0;
      chk("R3 lock sticky", lock_q, 1);
   endtask

   task automatic t_page2();
      do_req("R5 below", mk(2, 128, 31), 0, 1, 0, 43);
      do_req("R5 low edge", mk(2, 129, 0), 1, 0, 0, 43);
      do_req("R5 high edge", mk(2, 255, 27), 1, 0, 0, 43);
      do_req("R5 above", mk(2, 255, 28), 0, 1, 0, 43);
      do_req("R5 burn 43/16", mk(0, 43, 16), 1, 0, 0, -1);
      do_req("R5 locked", mk(2, 200, 0), 0, 1, 0, 43);
   endtask

   task automatic t_other();
      do_req("R6 page1", mk(1, 40, 0), 0, 1, 0, -1);
      do_req("R6 page3", mk(3, 200, 0), 0, 1, 0, -1);
      do_req("R6 page15", mk(15, 40, 0), 0, 1, 0, -1);
   endtask

   task automatic t_fail();
      set_fail = 1'b1;
      @(negedge clk); addr_wr = 1'b1; addr_wdata = mk(0, 41, 5);
      @(negedge clk); addr_wr = 1'b0;
      @(negedge clk); chk("R8 set issued", set_req, 1);
      @(negedge clk); chk("R8 err pulse", pgm_err, 1);
      set_fail = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 err held", err_flag, 1);
      err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R9 err cleared", err_flag, 0);
   endtask

   task automatic t_tbit();
      do_req("R10 col28", mk(0, 0, 28), 1, 0, 1, -1);
      do_req("R10 col27", mk(0, 0, 27), 1, 0, 0, -1);
      do_req("R10 other row", mk(0, 1, 30), 1, 0, 0, -1);
      cfg_word = 8'h00;
      do_req("R10 denied", mk(0, 0, 30), 0, 1, 0, -1);
      cfg_word = 8'h02;
   endtask

   task automatic t_busy();
      int dones = 0;
      @(negedge clk); addr_wr = 1'b1; addr_wdata = mk(0, 42, 0);
      @(negedge clk); addr_wdata = mk(1, 42, 0);
      if (pgm_done) dones++;
      @(negedge clk); addr_wr = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (pgm_done) begin
            dones++;
            chk("R11 ignored write no err", pgm_err, 0);
         end
         @(negedge clk);
      end
      chk("R11 one done", dones, 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) fuse0[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_enable();
      t_unmapped();
      t_table();
      t_sticky();
      t_page2();
      t_other();
      t_fail();
      t_tbit();
      t_busy();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule